// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

The block takes one track candidate per clock: six signed fixed-point hit coordinates, one for each detector layer, and the index of the constant set that belongs to the candidate's road or sector. It turns the candidate into fitted track parameters and a fit-quality figure using only stored linear constants. Each output row is an offset plus a weighted sum of the six coordinates. The first `NPAR` rows are emitted as track parameters, for example impact parameter and angle. The remaining `NCON` rows are constraint residuals. Each residual is squared and clipped, and the clipped squares are added into a chi-square-like sum. That sum is compared against a programmable cut, which gives an accept flag.

The constants are computed offline from geometry and alignment and are loaded through a single-word write port. Every word is addressed by set, row and column. While a word is being written, no candidate is taken, so a candidate always sees one consistent constant set. The datapath is a fixed four-stage pipeline with no output stall. Results leave in the same order the candidates arrived.

Top module: `lin_track_fitter`

## Requirements
- R1: After reset, `out_valid` is low and every stored constant is zero. A candidate sent right after reset therefore gives zero parameters and a zero quality value.
- R2: `in_ready` is low in every cycle in which `cfg_we` is high and high in every other cycle. A candidate is taken only in a cycle where `in_valid` and `in_ready` are both high.
- R3: Track parameter p (0 ≤ p < NPAR) uses constant row p. It equals the row's offset (column NLAYER) plus the sum over layers l of weight (column l) times coordinate l. It is given at full precision as a signed ACCW-bit value in `out_param[p*ACCW +: ACCW]`. Coordinate l is `in_coord[l*CW +: CW]`, and all coordinates and constants are two's complement.
- R4: Rows NPAR to NPAR+NCON-1 are constraint rows and are evaluated in the same way as parameter rows. `out_chi` is the sum of the squares of these residuals.
- R5: Each squared residual is clipped to 2^SQW-1 before the sum, so `out_chi` never exceeds NCON·(2^SQW-1).
- R6: `out_accept` is high exactly when `out_valid` is high and `out_chi` ≤ `chi_cut`. Equality accepts.
- R7: A candidate taken in cycle n produces `out_valid` high in cycle n+4. Back-to-back candidates produce back-to-back results in input order.
- R8: Each candidate uses only the constant set named by `in_set`. Different sets hold independent constants.
- R9: A write whose row is NPAR+NCON or above, or whose column is above NLAYER, changes no stored constant.
- R10: A candidate uses the constants stored in the cycle it is taken. A write in a later cycle does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Constant word write strobe |
| cfg_set | input | SETW (3) | Constant set to write |
| cfg_row | input | ROWW (3) | Row: parameters first, then constraints |
| cfg_col | input | COLW (3) | Column: layer weight 0..NLAYER-1, offset at NLAYER |
| cfg_data | input | KW (12) | Signed constant value |
| chi_cut | input | CHW (34) | Acceptance threshold on the quality sum |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate can be taken this cycle |
| in_set | input | SETW (3) | Constant set for the candidate |
| in_coord | input | NLAYER*CW (72) | Packed signed coordinates, layer 0 in the low bits |
| out_valid | output | 1 | Result present |
| out_param | output | NPAR*ACCW (54) | Packed signed track parameters |
| out_chi | output | CHW (34) | Clipped quality sum |
| out_accept | output | 1 | Quality sum within the cut |

## Verification
`in_ready` is a combinational function of the write strobe and is checked in the same cycle a write is driven. Every fit result is due exactly four cycles after the accepting cycle. The bench timestamps each candidate at its accepting edge and checks that the matching result appears three edges later, reading it at the falling edge after the fourth register stage. Expected values come from the bench's own model of the constant store, which is updated after the expectation for the same edge is computed. This is how the ordering of a write against an in-flight candidate is pinned down. Any output that appears without a pending expectation, or any expectation still pending after the pipeline has drained, counts as a failure.

// File: rtl/fit_pkg.sv
package fit_pkg;

  localparam int unsigned DEF_NLAYER = 6;
  localparam int unsigned DEF_NPAR   = 2;
  localparam int unsigned DEF_NCON   = 4;
  localparam int unsigned DEF_NSET   = 8;
  localparam int unsigned DEF_CW     = 12;
  localparam int unsigned DEF_KW     = 12;
  localparam int unsigned DEF_SQW    = 32;

  // square of a residual, clipped to an w-bit unsigned ceiling
  function automatic logic [63:0] sq_clip(input logic signed [63:0] v, input int unsigned w);
    logic [63:0] s;
    logic [63:0] lim;
    s   = v * v;
    lim = (64'd1 << w) - 64'd1;
    return (s > lim) ? lim : s;
  endfunction

  // accumulator width for a dot product of n terms plus one offset
  function automatic int unsigned dot_width(input int unsigned cw, input int unsigned kw,
                                            input int unsigned n);
    return cw + kw + $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fit_const_store.sv
module fit_const_store #(
  parameter int unsigned NSET = 8,
  parameter int unsigned NROW = 6,
  parameter int unsigned NCOL = 7,
  parameter int unsigned KW   = 12,
  localparam int unsigned SETW = $clog2(NSET),
  localparam int unsigned ROWW = $clog2(NROW),
  localparam int unsigned COLW = $clog2(NCOL)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SETW-1:0]          wr_set,
  input  logic [ROWW-1:0]          wr_row,
  input  logic [COLW-1:0]          wr_col,
  input  logic [KW-1:0]            wr_data,
  input  logic [SETW-1:0]          rd_set,
  output logic [NROW*NCOL*KW-1:0]  rd_consts
);

  logic [KW-1:0] mem [NSET][NROW][NCOL];
  logic          wr_hit;

  assign wr_hit = wr_en && (32'(wr_set) < NSET) && (32'(wr_row) < NROW) && (32'(wr_col) < NCOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(NSET); s++)
        for (int r = 0; r < int'(NROW); r++)
          for (int c = 0; c < int'(NCOL); c++)
            mem[s][r][c] <= '0;
    end else if (wr_hit) begin
      mem[wr_set][wr_row][wr_col] <= wr_data;
    end
  end

  for (genvar r = 0; r < int'(NROW); r++) begin : g_row
    for (genvar c = 0; c < int'(NCOL); c++) begin : g_col
      assign rd_consts[(r*NCOL+c)*KW +: KW] = mem[rd_set][r][c];
    end
  end

endmodule

// File: rtl/fit_row_unit.sv
module fit_row_unit #(
  parameter int unsigned NLAYER = 6,
  parameter int unsigned CW     = 12,
  parameter int unsigned KW     = 12,
  parameter int unsigned ACCW   = 27,
  localparam int unsigned PW    = CW + KW
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NLAYER*CW-1:0]       coords,
  input  logic [(NLAYER+1)*KW-1:0]   consts,
  output logic signed [ACCW-1:0]     row_sum
);

  logic signed [PW-1:0]   prod_q [NLAYER];
  logic signed [KW-1:0]   off_q;
  logic signed [ACCW-1:0] acc_d;

  for (genvar l = 0; l < int'(NLAYER); l++) begin : g_lay
    logic signed [CW-1:0] cv;
    logic signed [KW-1:0] wv;
    assign cv = coords[l*CW +: CW];
    assign wv = consts[l*KW +: KW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[l] <= '0;
      else        prod_q[l] <= PW'(cv) * PW'(wv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= consts[NLAYER*KW +: KW];
  end

  always_comb begin
    acc_d = ACCW'(off_q);
    for (int l = 0; l < int'(NLAYER); l++)
      acc_d = acc_d + ACCW'(prod_q[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_sum <= '0;
    else        row_sum <= acc_d;
  end

endmodule

// File: rtl/fit_quality.sv
module fit_quality import fit_pkg::*; #(
  parameter int unsigned NCON = 4,
  parameter int unsigned ACCW = 27,
  parameter int unsigned SQW  = 32,
  parameter int unsigned CHW  = 34
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCON*ACCW-1:0]   resid,
  input  logic                   sq_valid,
  input  logic [CHW-1:0]         cut,
  output logic [NCON-1:0]        clip_hit,
  output logic [CHW-1:0]         chi,
  output logic                   accept
);

  logic [SQW-1:0] sq_q [NCON];
  logic [CHW-1:0] chi_d;

  for (genvar k = 0; k < int'(NCON); k++) begin : g_con
    logic signed [ACCW-1:0] rk;
    logic [SQW-1:0]         sq_d;
    assign rk          = resid[k*ACCW +: ACCW];
    assign sq_d        = SQW'(sq_clip(64'(rk), SQW));
    assign clip_hit[k] = &sq_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq_q[k] <= '0;
      else        sq_q[k] <= sq_d;
    end
  end

  always_comb begin
    chi_d = '0;
    for (int k = 0; k < int'(NCON); k++)
      chi_d = chi_d + CHW'(sq_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chi    <= '0;
      accept <= 1'b0;
    end else begin
      chi    <= chi_d;
      accept <= sq_valid && (chi_d <= cut);
    end
  end

endmodule

// File: rtl/lin_track_fitter.sv
module lin_track_fitter import fit_pkg::*; #(
  parameter int unsigned NLAYER = DEF_NLAYER,
  parameter int unsigned NPAR   = DEF_NPAR,
  parameter int unsigned NCON   = DEF_NCON,
  parameter int unsigned NSET   = DEF_NSET,
  parameter int unsigned CW     = DEF_CW,
  parameter int unsigned KW     = DEF_KW,
  parameter int unsigned SQW    = DEF_SQW,
  localparam int unsigned NROW  = NPAR + NCON,
  localparam int unsigned NCOL  = NLAYER + 1,
  localparam int unsigned SETW  = $clog2(NSET),
  localparam int unsigned ROWW  = $clog2(NROW),
  localparam int unsigned COLW  = $clog2(NCOL),
  localparam int unsigned ACCW  = dot_width(CW, KW, NLAYER),
  localparam int unsigned CHW   = SQW + $clog2(NCON)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SETW-1:0]         cfg_set,
  input  logic [ROWW-1:0]         cfg_row,
  input  logic [COLW-1:0]         cfg_col,
  input  logic [KW-1:0]           cfg_data,
  input  logic [CHW-1:0]          chi_cut,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SETW-1:0]         in_set,
  input  logic [NLAYER*CW-1:0]    in_coord,
  output logic                    out_valid,
  output logic [NPAR*ACCW-1:0]    out_param,
  output logic [CHW-1:0]          out_chi,
  output logic                    out_accept
);

  localparam int unsigned NSTG = 4;
  localparam int unsigned RKW  = NCOL * KW;

  logic                     in_fire;
  logic [NSTG-1:0]          vld;
  logic [NROW*RKW-1:0]      consts;
  logic signed [ACCW-1:0]   row_val [NROW];
  logic [NPAR*ACCW-1:0]     par_s2, par_s3, par_s4;
  logic [NCON*ACCW-1:0]     resid_s2;
  logic [NCON-1:0]          clip_hit;

  // candidates stall for the single cycle of each constant write
  assign in_ready = !cfg_we;
  assign in_fire  = in_valid && in_ready;

  fit_const_store #(.NSET(NSET), .NROW(NROW), .NCOL(NCOL), .KW(KW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_set(cfg_set), .wr_row(cfg_row), .wr_col(cfg_col), .wr_data(cfg_data),
    .rd_set(in_set), .rd_consts(consts)
  );

  for (genvar r = 0; r < int'(NROW); r++) begin : g_row
    fit_row_unit #(.NLAYER(NLAYER), .CW(CW), .KW(KW), .ACCW(ACCW)) u_row (
      .clk(clk), .rst_n(rst_n),
      .coords(in_coord),
      .consts(consts[r*RKW +: RKW]),
      .row_sum(row_val[r])
    );
  end

  for (genvar p = 0; p < int'(NPAR); p++) begin : g_par
    assign par_s2[p*ACCW +: ACCW] = row_val[p];
  end

  for (genvar k = 0; k < int'(NCON); k++) begin : g_res
    assign resid_s2[k*ACCW +: ACCW] = row_val[NPAR+k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      par_s3 <= '0;
      par_s4 <= '0;
    end else begin
      vld    <= {vld[NSTG-2:0], in_fire};
      par_s3 <= par_s2;
      par_s4 <= par_s3;
    end
  end

  fit_quality #(.NCON(NCON), .ACCW(ACCW), .SQW(SQW), .CHW(CHW)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .resid(resid_s2), .sq_valid(vld[2]), .cut(chi_cut),
    .clip_hit(clip_hit), .chi(out_chi), .accept(out_accept)
  );

  assign out_valid = vld[NSTG-1];
  assign out_param = par_s4;

endmodule

// File: rtl/fit_checker.sv
module fit_checker #(
  parameter int unsigned NCON = 4,
  parameter int unsigned SQW  = 32,
  parameter int unsigned CHW  = 34
)(
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           in_fire,
  input logic           in_ready,
  input logic [NCON-1:0] clip_hit,
  input logic [CHW-1:0] chi_cut,
  input logic           out_valid,
  input logic [CHW-1:0] out_chi,
  input logic           out_accept
);

  localparam logic [CHW-1:0] SQ_MAX  = CHW'({SQW{1'b1}});
  localparam logic [CHW-1:0] CHI_MAX = CHW'(SQ_MAX * CHW'(NCON));

  assert_stall_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_ready);

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> ##4 out_valid);

  assert_accept_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_accept);

  assert_cut_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $stable(chi_cut)) |-> (out_accept == (out_chi <= chi_cut)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chi <= CHI_MAX));

  assert_clip_flags_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(clip_hit));

endmodule

bind lin_track_fitter fit_checker #(.NCON(NCON), .SQW(SQW), .CHW(CHW)) u_fit_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_fire(in_fire), .in_ready(in_ready),
  .clip_hit(clip_hit), .chi_cut(chi_cut), .out_valid(out_valid), .out_chi(out_chi),
  .out_accept(out_accept)
);

// File: tb/test_lin_track_fitter.sv
`timescale 1ns/1ps
module test_lin_track_fitter;

  localparam int NL = 6, NP = 2, NC = 4, NS = 8, CW = 12, KW = 12, SQW = 32;
  localparam int NROW = NP + NC, NCOL = NL + 1;
  localparam int ACCW = 27, CHW = 34;
  localparam longint SQMAX = (64'sd1 <<< SQW) - 1;
  localparam int LAT_EDGES = 3; // accepting edge to the edge that raises out_valid

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_set = '0, cfg_row = '0, cfg_col = '0;
  logic [KW-1:0] cfg_data = '0;
  logic [CHW-1:0] chi_cut = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_set = '0;
  logic [NL*CW-1:0] in_coord = '0;
  logic out_valid;
  logic [NP*ACCW-1:0] out_param;
  logic [CHW-1:0] out_chi;
  logic out_accept;

  always #4 clk = ~clk;

  lin_track_fitter i_lin_track_fitter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_row(cfg_row),
    .cfg_col(cfg_col), .cfg_data(cfg_data), .chi_cut(chi_cut), .in_valid(in_valid),
    .in_ready(in_ready), .in_set(in_set), .in_coord(in_coord), .out_valid(out_valid),
    .out_param(out_param), .out_chi(out_chi), .out_accept(out_accept)
  );

  int checks = 0, fails = 0, cyc = 0;
  string cur_tag = "R1";
  int bm [NS][NROW][NCOL];
  longint ep [64][NP];
  longint ec [64];
  string et [64];
  int ecyc [64];
  int wp = 0, rp = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // bench model: expectation for the edge first, then the constant write of the same edge
  always @(posedge clk) begin
    longint rv [NROW];
    longint a, sq, chi;
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < NROW; r++)
          for (int c = 0; c < NCOL; c++) bm[s][r][c] = 0;
    end else begin
      if (in_valid && !cfg_we) begin
        for (int r = 0; r < NROW; r++) begin
          a = longint'(bm[in_set][r][NL]);
          for (int l = 0; l < NL; l++)
            a = a + longint'(bm[in_set][r][l]) * longint'($signed(in_coord[l*CW +: CW]));
          rv[r] = a;
        end
        chi = 0;
        for (int k = 0; k < NC; k++) begin
          sq = rv[NP+k] * rv[NP+k];
          if (sq > SQMAX) sq = SQMAX;
          chi = chi + sq;
        end
        for (int p = 0; p < NP; p++) ep[wp%64][p] = rv[p];
        ec[wp%64] = chi;
        et[wp%64] = cur_tag;
        ecyc[wp%64] = cyc;
        wp++;
      end
      if (cfg_we && int'(cfg_row) < NROW && int'(cfg_col) < NCOL)
        bm[cfg_set][cfg_row][cfg_col] = int'($signed(cfg_data));
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rp == wp) chk(1'b0, "R7", "output without pending candidate", 1, 0);
      else begin
        for (int p = 0; p < NP; p++)
          chk(longint'($signed(out_param[p*ACCW +: ACCW])) == ep[rp%64][p], et[rp%64],
              "track parameter", longint'($signed(out_param[p*ACCW +: ACCW])), ep[rp%64][p]);
        chk(longint'(out_chi) == ec[rp%64], et[rp%64], "quality sum", longint'(out_chi), ec[rp%64]);
        chk(out_accept == (ec[rp%64] <= longint'(chi_cut)), et[rp%64], "accept flag",
            longint'(out_accept), longint'(ec[rp%64] <= longint'(chi_cut)));
        chk(cyc - ecyc[rp%64] == LAT_EDGES, "R7", "latency", cyc - ecyc[rp%64], LAT_EDGES);
        rp++;
      end
    end
  end

  task automatic wr(input int s, input int r, input int c, input int d);
    cfg_we = 1'b1; cfg_set = 3'(s); cfg_row = 3'(r); cfg_col = 3'(c); cfg_data = KW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wrow(input int s, input int r, input int w [NCOL]);
    for (int c = 0; c < NCOL; c++) wr(s, r, c, w[c]);
  endtask

  task automatic send(input int s, input int x [NL]);
    in_valid = 1'b1; in_set = 3'(s);
    for (int l = 0; l < NL; l++) in_coord[l*CW +: CW] = CW'(x[l]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    chk(rp == wp, cur_tag, "pending results after drain", wp - rp, 0);
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R2", "in_ready idle", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chi_cut = '0;
    send(3, '{100, -200, 300, -400, 500, 2047});
    drain();
  endtask

  task automatic t_params();
    cur_tag = "R3";
    wrow(0, 0, '{3, -5, 7, 11, -13, 17, 100});
    wrow(0, 1, '{-2048, 2047, 1, 0, -1, 9, -2048});
    chi_cut = '1;
    send(0, '{1, 2, 3, 4, 5, 6});
    send(0, '{-2048, -2048, -2048, -2048, -2048, -2048});
    send(0, '{2047, 2047, 2047, 2047, 2047, 2047});
    send(0, '{-7, 0, 1000, -1000, 33, -1});
    drain();
  endtask

  task automatic t_quality();
    cur_tag = "R4";
    wrow(1, 2, '{1, 1, 0, 0, 0, 0, -5});
    wrow(1, 3, '{0, -2, 3, 0, 0, 0, 0});
    wrow(1, 4, '{0, 0, 0, 4, -4, 0, 1});
    wrow(1, 5, '{1, 0, 0, 0, 0, -1, 0});
    wrow(1, 0, '{1, 0, 0, 0, 0, 0, 0});
    chi_cut = '1;
    send(1, '{10, 20, 30, 40, 50, 60});
    send(1, '{-3, 8, -1, 5, 5, 2});
    send(1, '{0, 0, 0, 0, 0, 0});
    drain();
  endtask

  task automatic t_saturate();
    cur_tag = "R5";
    wrow(2, 2, '{2047, 0, 0, 0, 0, 0, 0});
    wrow(2, 3, '{0, -2048, 0, 0, 0, 0, 0});
    wrow(2, 4, '{0, 0, 1, 0, 0, 0, 0});
    chi_cut = '1;
    send(2, '{2047, 2047, 3, 0, 0, 0});   // two clipped squares plus 9
    send(2, '{-2048, 0, 0, 0, 0, 0});     // one clipped square
    send(2, '{31, 31, 0, 0, 0, 0});       // both just below the ceiling
    drain();
  endtask

  task automatic t_cut();
    cur_tag = "R6";
    wr(4, 2, 0, 1);
    chi_cut = CHW'(100);
    send(4, '{10, 0, 0, 0, 0, 0});        // 100 equals the cut: accepted
    send(4, '{11, 0, 0, 0, 0, 0});        // 121: rejected
    send(4, '{-9, 0, 0, 0, 0, 0});        // 81: accepted
    drain();
    chi_cut = CHW'(99);
    send(4, '{10, 0, 0, 0, 0, 0});        // 100 above 99: rejected
    drain();
  endtask

  task automatic t_stream();
    int x [NL];
    cur_tag = "R7";
    chi_cut = CHW'(64'd5000000000);
    for (int i = 0; i < 20; i++) begin
      for (int l = 0; l < NL; l++) x[l] = ((i * 317 + l * 911) % 4096) - 2048;
      send(i % 3, x);
    end
    drain();
  endtask

  task automatic t_sets();
    cur_tag = "R8";
    wrow(5, 0, '{1, 1, 1, 1, 1, 1, 0});
    wrow(6, 0, '{-1, 2, -3, 4, -5, 6, 7});
    chi_cut = '1;
    send(5, '{5, 6, 7, 8, 9, 10});
    send(6, '{5, 6, 7, 8, 9, 10});
    send(5, '{-1, -1, -1, -1, -1, -1});
    drain();
  endtask

  task automatic t_ignore();
    cur_tag = "R9";
    wr(0, 6, 0, 55);
    wr(0, 7, 3, 9);
    wr(0, 0, 7, 55);
    wr(0, 2, 7, -300);
    send(0, '{1, 2, 3, 4, 5, 6});
    send(0, '{-9, 4, 0, 12, -100, 7});
    drain();
  endtask

  task automatic t_inflight();
    cur_tag = "R10";
    wr(7, 0, 0, 3);
    send(7, '{100, 0, 0, 0, 0, 0});
    wr(7, 0, 0, 5);
    send(7, '{100, 0, 0, 0, 0, 0});
    drain();
  endtask

  task automatic t_ready();
    cur_tag = "R2";
    cfg_we = 1'b1; cfg_set = 3'd6; cfg_row = 3'd0; cfg_col = 3'd1; cfg_data = KW'(7);
    in_valid = 1'b1; in_set = 3'd6;
    for (int l = 0; l < NL; l++) in_coord[l*CW +: CW] = CW'(l + 1);
    #1;
    chk(in_ready == 1'b0, "R2", "in_ready during write", longint'(in_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R2", "in_ready after write", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    drain();
  endtask

  initial begin
    t_reset();
    t_params();
    t_quality();
    t_saturate();
    t_cut();
    t_stream();
    t_sets();
    t_ignore();
    t_inflight();
    t_ready();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule